// File: doc/BRIEF.md
# Vector Drive Clock Qualifier

This block decides, cycle by cycle, whether the vector clock may advance the pattern driver. It produces a registered qualify strobe that is high only when four conditions hold together: driving has been started, no stop or end-of-sequence has occurred since the last arming, the enable condition is met, and no wait handshake is pending. Four external control lines (start, stop, enable and wait) are brought into the clock domain through a synchronizer chain. Start and stop act on a chosen edge, enable on a chosen level, and the wait resume on a chosen edge.

Before a run, software holds the arm control low. This clears the run state and sets the handshake flag. Releasing the control lets the run begin, either through a software force-start or through the selected edge on the start line. A stop edge or the sequencer's done flag ends the run, and the run stays ended until the block is armed again. When the sequencer issues a vector that carries a wait flag, driving is suspended on the next clock. It resumes after the selected edge on the wait line. A 4-bit status nibble, updated in the same cycle as the strobe, shows the internal state.

Top module: `vec_clk_qualifier`

## Requirements
- R1: `qualify` is a registered output. It is 1 only when started is set, halted is clear, the enable condition holds and the handshake flag is set.
- R2: Started is set by `force_start`, which takes effect at the next clock. It is also set by a start-line edge: rising when `start_pol`=1, falling when `start_pol`=0.
- R3: Halted is set by a stop-line edge: rising when `stop_pol`=1, falling when `stop_pol`=0. An edge of the other direction has no effect.
- R4: `seq_done`=1 sets halted at the next clock, so `qualify` is 0 after that edge.
- R5: Once halted is set, it stays set while `arm_n`=1. During that time neither a start edge nor `force_start` can set started.
- R6: The enable condition is `ena_always`=1, or the synchronized `ext_enable` equal to `ena_level`.
- R7: A rising edge of `vec_wait_flag` clears the handshake flag at the next clock. Keeping the flag high does not clear it again.
- R8: While the handshake flag is clear, it is set again by a rising edge of (`ext_wait` XOR `hs_pol`). With `hs_pol`=0 that is a rising edge of `ext_wait`; with `hs_pol`=1 it is a falling edge. The other edge direction has no effect.
- R9: With `arm_n`=0 at a clock edge, started and halted are cleared and the handshake flag is set.
- R10: `status` bit 0 is started, bit 1 is halted, bit 2 is the handshake flag and bit 3 is the enable condition. During reset, `status` is 4'b0100 and `qualify` is 0.
- R11: An external line passes through a two-flop synchronizer. A change driven before clock edge k shows on `qualify` and `status` after edge k+2, not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arm_n | input | 1 | Arm control; 0 initializes the run and handshake state |
| force_start | input | 1 | Software start request |
| start_pol | input | 1 | Start edge select, 1 = rising |
| stop_pol | input | 1 | Stop edge select, 1 = rising |
| ena_always | input | 1 | Forces the enable condition true |
| ena_level | input | 1 | Level of `ext_enable` that satisfies enable |
| hs_pol | input | 1 | Wait resume edge select, 0 = rising, 1 = falling |
| ext_start | input | 1 | Asynchronous start line |
| ext_stop | input | 1 | Asynchronous stop line |
| ext_enable | input | 1 | Asynchronous enable line |
| ext_wait | input | 1 | Asynchronous wait handshake line |
| seq_done | input | 1 | Sequencer end-of-vectors flag |
| vec_wait_flag | input | 1 | Wait flag of the vector being issued |
| qualify | output | 1 | Clock-qualify strobe |
| status | output | 4 | {enable, handshake flag, halted, started} |

## Verification
The assertions check on every cycle that the strobe never rises unless the run and handshake state allows it. They also check that halted stays set until arming, that done and a wait-flag edge act on the very next clock, that arming restores the handshake flag, and that a synchronized edge lasts a single cycle. Only the bench scenarios can show the polarity selections. These cover every start, stop and wait polarity against both edge directions, and all eight enable combinations. The scenarios also cover the exact three-edge latency of the external lines, and that a start attempt after a halt is ignored.

// File: rtl/vcq_pkg.sv
`timescale 1ns/1ps
package vcq_pkg;
  localparam int CH_START = 0;
  localparam int CH_STOP  = 1;
  localparam int CH_ENA   = 2;
  localparam int CH_WAIT  = 3;
  localparam int NUM_CH   = 4;

  localparam int ST_START = 0;
  localparam int ST_HALT  = 1;
  localparam int ST_HS    = 2;
  localparam int ST_ENA   = 3;
  localparam int ST_W     = 4;
endpackage

// File: rtl/vcq_sync.sv
`timescale 1ns/1ps
module vcq_sync #(
  parameter int N      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] din,
  output logic [N-1:0] level,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  for (genvar i = 0; i < N; i++) begin : g_ch
    logic [STAGES-1:0] chain;
    logic              prev;

    always_ff @(posedge clk) begin
      if (rst) begin
        chain <= '0;
        prev  <= 1'b0;
      end else begin
        chain <= {chain[STAGES-2:0], din[i]};
        prev  <= chain[STAGES-1];
      end
    end

    assign level[i] = chain[STAGES-1];
    assign rise[i]  = chain[STAGES-1] & ~prev;
    assign fall[i]  = ~chain[STAGES-1] & prev;

    // an edge is seen for exactly one cycle
    AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (rst)
      rise[i] |=> !rise[i]); // R11
  end
endmodule

// File: rtl/vcq_run_latch.sv
`timescale 1ns/1ps
module vcq_run_latch (
  input  logic clk,
  input  logic rst,
  input  logic arm_n,
  input  logic force_start,
  input  logic start_evt,
  input  logic stop_evt,
  input  logic seq_done,
  output logic started,
  output logic halted,
  output logic started_nxt,
  output logic halted_nxt
);
  always_comb begin
    if (!arm_n) begin
      started_nxt = 1'b0;
      halted_nxt  = 1'b0;
    end else begin
      started_nxt = started | (~halted & (force_start | start_evt));
      halted_nxt  = halted | stop_evt | seq_done;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      started <= 1'b0;
      halted  <= 1'b0;
    end else begin
      started <= started_nxt;
      halted  <= halted_nxt;
    end
  end

  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst)
    (halted && arm_n) |=> halted); // R5
  AST_DONE_HALTS: assert property (@(posedge clk) disable iff (rst)
    (arm_n && seq_done) |=> halted); // R4
  AST_NO_START_WHILE_HALTED: assert property (@(posedge clk) disable iff (rst)
    (arm_n && halted && !started) |=> !started); // R5
  AST_ARM_CLEARS: assert property (@(posedge clk) disable iff (rst)
    !arm_n |=> (!started && !halted)); // R9
endmodule

// File: rtl/vcq_hs_latch.sv
`timescale 1ns/1ps
module vcq_hs_latch (
  input  logic clk,
  input  logic rst,
  input  logic arm_n,
  input  logic wait_flag,
  input  logic resume_evt,
  output logic hs_en,
  output logic hs_nxt
);
  logic flag_d;
  logic flag_rise;

  assign flag_rise = wait_flag & ~flag_d;

  always_comb begin
    if (!arm_n)              hs_nxt = 1'b1;
    else if (flag_rise)      hs_nxt = 1'b0;
    else if (!hs_en && resume_evt) hs_nxt = 1'b1;
    else                     hs_nxt = hs_en;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hs_en  <= 1'b1;
      flag_d <= 1'b0;
    end else begin
      hs_en  <= hs_nxt;
      flag_d <= wait_flag;
    end
  end

  AST_WAIT_SUSPENDS: assert property (@(posedge clk) disable iff (rst)
    (arm_n && wait_flag && !flag_d) |=> !hs_en); // R7
  AST_ARM_SETS_HS: assert property (@(posedge clk) disable iff (rst)
    !arm_n |=> hs_en); // R9
  AST_HOLD_SUSPENDED: assert property (@(posedge clk) disable iff (rst)
    (arm_n && !hs_en && !resume_evt) |=> !hs_en); // R8
endmodule

// File: rtl/vec_clk_qualifier.sv
`timescale 1ns/1ps
module vec_clk_qualifier #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       arm_n,
  input  logic       force_start,
  input  logic       start_pol,
  input  logic       stop_pol,
  input  logic       ena_always,
  input  logic       ena_level,
  input  logic       hs_pol,
  input  logic       ext_start,
  input  logic       ext_stop,
  input  logic       ext_enable,
  input  logic       ext_wait,
  input  logic       seq_done,
  input  logic       vec_wait_flag,
  output logic       qualify,
  output logic [3:0] status
);
  import vcq_pkg::*;

  logic [NUM_CH-1:0] raw, lvl, rise, fall;
  logic start_evt, stop_evt, ena_ok;
  logic started, halted, started_nxt, halted_nxt;
  logic hs_en, hs_nxt;
  logic [ST_W-1:0] status_nxt;

  always_comb begin
    raw           = '0;
    raw[CH_START] = ext_start;
    raw[CH_STOP]  = ext_stop;
    raw[CH_ENA]   = ext_enable;
    raw[CH_WAIT]  = ext_wait ^ hs_pol;
  end

  vcq_sync #(.N(NUM_CH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(raw),
    .level(lvl), .rise(rise), .fall(fall)
  );

  assign start_evt = start_pol ? rise[CH_START] : fall[CH_START];
  assign stop_evt  = stop_pol  ? rise[CH_STOP]  : fall[CH_STOP];
  assign ena_ok    = ena_always | (lvl[CH_ENA] == ena_level);

  vcq_run_latch u_run (
    .clk(clk), .rst(rst), .arm_n(arm_n),
    .force_start(force_start), .start_evt(start_evt),
    .stop_evt(stop_evt), .seq_done(seq_done),
    .started(started), .halted(halted),
    .started_nxt(started_nxt), .halted_nxt(halted_nxt)
  );

  vcq_hs_latch u_hs (
    .clk(clk), .rst(rst), .arm_n(arm_n),
    .wait_flag(vec_wait_flag), .resume_evt(rise[CH_WAIT]),
    .hs_en(hs_en), .hs_nxt(hs_nxt)
  );

  always_comb begin
    status_nxt           = '0;
    status_nxt[ST_START] = started_nxt;
    status_nxt[ST_HALT]  = halted_nxt;
    status_nxt[ST_HS]    = hs_nxt;
    status_nxt[ST_ENA]   = ena_ok;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      qualify <= 1'b0;
      status  <= 4'b0100;
    end else begin
      qualify <= started_nxt & ~halted_nxt & hs_nxt & ena_ok;
      status  <= status_nxt;
    end
  end

  AST_QUAL_NEEDS_ALL: assert property (@(posedge clk) disable iff (rst)
    qualify |-> (started && !halted && hs_en)); // R1
  AST_STATUS_TRACKS: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (status[ST_HS] == hs_en && status[ST_HALT] == halted)); // R10
endmodule

// File: tb/vec_clk_qualifier_test.sv
`timescale 1ns/1ps
module vec_clk_qualifier_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic arm_n = 1'b1, force_start = 1'b0;
  logic start_pol = 1'b1, stop_pol = 1'b1;
  logic ena_always = 1'b1, ena_level = 1'b1, hs_pol = 1'b0;
  logic ext_start = 1'b0, ext_stop = 1'b0, ext_enable = 1'b0, ext_wait = 1'b0;
  logic seq_done = 1'b0, vec_wait_flag = 1'b0;
  logic qualify;
  logic [3:0] status;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  vec_clk_qualifier uut (
    .clk(clk), .rst(rst), .arm_n(arm_n), .force_start(force_start),
    .start_pol(start_pol), .stop_pol(stop_pol), .ena_always(ena_always),
    .ena_level(ena_level), .hs_pol(hs_pol), .ext_start(ext_start),
    .ext_stop(ext_stop), .ext_enable(ext_enable), .ext_wait(ext_wait),
    .seq_done(seq_done), .vec_wait_flag(vec_wait_flag),
    .qualify(qualify), .status(status)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic arm();
    arm_n = 1'b0;
    step(1);
    arm_n = 1'b1;
  endtask

  task automatic kick();
    force_start = 1'b1;
    step(1);
    force_start = 1'b0;
  endtask

  initial begin
    step(2);
    chk("R10 reset qualify", {3'b0, qualify}, 4'h0);
    chk("R10 reset status", status, 4'b0100);
    rst = 1'b0;
    step(4);

    // R2 / R11: start edge sweep over polarity and direction
    for (int pol = 0; pol < 2; pol++) begin
      for (int dir = 0; dir < 2; dir++) begin
        start_pol = pol[0];
        ext_start = (dir == 0);
        step(4);
        arm();
        ext_start = dir[0];
        step(2);
        chk("R11 no early start", {3'b0, qualify}, 4'h0);
        step(1);
        chk("R2 start edge", {3'b0, status[0]}, {3'b0, pol == dir});
        chk("R1 qualify after start", {3'b0, qualify}, {3'b0, pol == dir});
      end
    end

    // R6: enable sweep
    arm();
    kick();
    chk("R2 force start", {3'b0, qualify}, 4'h1);
    for (int ea = 0; ea < 2; ea++)
      for (int lv = 0; lv < 2; lv++)
        for (int e = 0; e < 2; e++) begin
          ena_always = ea[0];
          ena_level  = lv[0];
          ext_enable = e[0];
          step(3);
          chk("R6 enable bit", {3'b0, status[3]}, {3'b0, (ea == 1) || (e == lv)});
          chk("R1 enable gating", {3'b0, qualify}, {3'b0, (ea == 1) || (e == lv)});
        end
    ena_always = 1'b1;

    // R3 / R10: stop edge sweep
    for (int pol = 0; pol < 2; pol++) begin
      for (int dir = 0; dir < 2; dir++) begin
        stop_pol = pol[0];
        ext_stop = (dir == 0);
        step(4);
        arm();
        kick();
        ext_stop = dir[0];
        step(3);
        chk("R3 stop edge", {3'b0, qualify}, {3'b0, pol != dir});
        chk("R10 status nibble", status, {2'b11, (pol == dir) ? 1'b1 : 1'b0, 1'b1});
      end
    end

    // R4 / R5 / R9: done halts, halt is sticky, arming clears
    start_pol = 1'b1;
    ext_start = 1'b0;
    step(4);
    arm();
    seq_done = 1'b1;
    step(1);
    seq_done = 1'b0;
    chk("R4 done halts", {3'b0, status[1]}, 4'h1);
    ext_start = 1'b1;
    step(3);
    chk("R5 start edge ignored", {3'b0, status[0]}, 4'h0);
    kick();
    chk("R5 force ignored", {3'b0, status[0]}, 4'h0);
    chk("R5 qualify held low", {3'b0, qualify}, 4'h0);
    arm();
    chk("R9 arm clears halt", status[1:0], 4'h0);
    kick();
    seq_done = 1'b1;
    step(1);
    seq_done = 1'b0;
    chk("R4 done clears qualify", {3'b0, qualify}, 4'h0);

    // R7 / R8 / R9: handshake for both resume polarities
    for (int pol = 0; pol < 2; pol++) begin
      hs_pol   = pol[0];
      ext_wait = ~pol[0];
      step(4);
      arm();
      kick();
      chk("R1 running before wait", {3'b0, qualify}, 4'h1);
      vec_wait_flag = 1'b1;
      step(1);
      chk("R7 suspend qualify", {3'b0, qualify}, 4'h0);
      chk("R7 suspend status", {3'b0, status[2]}, 4'h0);
      ext_wait = pol[0];
      step(3);
      chk("R8 wrong edge ignored", {3'b0, status[2]}, 4'h0);
      ext_wait = ~pol[0];
      step(3);
      chk("R8 resume status", {3'b0, status[2]}, 4'h1);
      chk("R8 resume qualify", {3'b0, qualify}, 4'h1);
      step(2);
      chk("R7 held flag no resuspend", {3'b0, qualify}, 4'h1);
      vec_wait_flag = 1'b0;
      step(1);
      vec_wait_flag = 1'b1;
      step(1);
      chk("R7 second wait", {3'b0, status[2]}, 4'h0);
      arm();
      chk("R9 arm sets handshake", {3'b0, status[2]}, 4'h1);
      vec_wait_flag = 1'b0;
      step(1);
    end

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule